// File: doc/BRIEF.md
# Converter Result Read Port

This block is the device-side serial logic that sits between a converter's result path and a host on a four-wire serial link. A conversion-done strobe arrives with a 24-bit result. The block holds that result in a staging register for a fixed update window. At the end of the window it moves the result into the output register and pulls the active-low data-ready line low.

The host clocks an 8-bit read opcode in on DIN. The block then shifts the result out on DOUT, most significant bit first. A checksum byte can follow the three data bytes. If the host keeps clocking, the same result is sent again from its top bit.

Data-ready has two behaviours:
- **Gate mode:** data-ready clears on the first clock falling edge of the read.
- **Pulse mode:** data-ready holds until the next conversion strobe.

A read opcode that completes inside the update window is refused and flagged. A new result never replaces the output register while a frame is being shifted.

All pins are sampled by the system clock through a short synchronizer. The serial clock must therefore run several times slower than the system clock.

Top module: `adc_rdport`

## Requirements
- R1: DIN is sampled on serial-clock falling edges, MSB first. Each group of 8 bits forms an opcode. Opcode 0x12 starts a read frame. Any other opcode is ignored and DOUT stays low.
- R2: DOUT changes only on serial-clock rising edges. The first rising edge after an accepted opcode presents result bit 23. The data bytes follow in order: high, middle, low.
- R3: When `csum_en` is 1, a fourth byte follows the data bytes. It equals (high + middle + low + 0x9B) mod 256. When `csum_en` is 0, the frame is 24 bits long.
- R4: Rising edges beyond the frame length repeat the same frame from bit 23.
- R5: A `conv_done` strobe raises `drdy_n`. `UPD_CYC` (20) system-clock cycles later, the staged result is loaded and `drdy_n` falls.
- R6: In gate mode (`pulse_mode`=0), `drdy_n` rises on the first serial-clock falling edge after the read opcode is accepted.
- R7: In pulse mode (`pulse_mode`=1), `drdy_n` stays low through a read, until the next `conv_done`.
- R8: A read opcode that completes while the update window is counting pulses `rd_err` for one cycle. No frame starts, and DOUT stays low.
- R9: While `cs_n` is high, `dout_en` is 0, any frame in progress ends, and the opcode bit count restarts.
- R10: While `cs_n` is low and no frame is active, DOUT is driven low (`dout_en`=1, `dout`=0).
- R11: If the window ends during a frame, the load waits. The frame then ends at its next frame boundary: DOUT goes low, the load happens and `drdy_n` falls. Bits sent before that boundary come from the old result.
- R12: `drdy_bit` always equals `drdy_n`, so data-ready can be polled as a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle strobe: a new result is on `conv_data` |
| conv_data | input | 24 | Conversion result |
| csum_en | input | 1 | Append the checksum byte to each frame |
| pulse_mode | input | 1 | 1 = pulse control of data-ready, 0 = gate control |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| dout_en | output | 1 | Output enable for DOUT; 0 means high impedance |
| drdy_n | output | 1 | Active-low data-ready |
| drdy_bit | output | 1 | Status copy of data-ready |
| rd_err | output | 1 | One-cycle pulse: read refused inside the update window |

## Verification
The bench builds the block with its default parameters. These are a 20-cycle update window, opcode 0x12, checksum constant 0x9B and a two-stage synchronizer.

With a serial half-period of 8 system clocks, the bench can finish the opcode's eighth bit either inside or well past the window. It does this by holding back the last bit around a strobe, which makes both the refusal and the acceptance at the window edge reachable. The same settings let a strobe land mid-frame, so the deferred load and the early frame end can be observed.

// File: rtl/adc_rdport.sv
module adc_rdport #(
  parameter int          UPD_CYC  = 20,
  parameter logic [7:0]  RD_OPC   = 8'h12,
  parameter logic [7:0]  CSUM_KEY = 8'h9B,
  parameter int          SYNC_N   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        conv_done,
  input  logic [23:0] conv_data,
  input  logic        csum_en,
  input  logic        pulse_mode,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        din,
  output logic        dout,
  output logic        dout_en,
  output logic        drdy_n,
  output logic        drdy_bit,
  output logic        rd_err
);
  localparam int DW = 24;
  localparam int NB = DW + 8;
  localparam int PW = $clog2(NB);
  localparam int CW = $clog2(UPD_CYC + 1);
  localparam logic [PW-1:0] TOP    = PW'(NB - 1);
  localparam logic [PW-1:0] LAST_C = PW'(NB - 1);
  localparam logic [PW-1:0] LAST_D = PW'(DW - 1);

  logic [SYNC_N:0] sclk_s, cs_s, din_s;
  logic [DW-1:0]   res_q, stage_q;
  logic [CW-1:0]   cnt_q;
  logic [PW-1:0]   ptr_q;
  logic [6:0]      cmd_q;
  logic [2:0]      cbit_q;
  logic pend_q, drdy_q, frame_q, first_q, started_q, dout_q, err_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      din_s  <= '0;
    end else begin
      sclk_s <= {sclk_s[SYNC_N-1:0], sclk};
      cs_s   <= {cs_s[SYNC_N-1:0], cs_n};
      din_s  <= {din_s[SYNC_N-1:0], din};
    end

  wire rise  = sclk_s[SYNC_N-1] & ~sclk_s[SYNC_N];
  wire fall  = ~sclk_s[SYNC_N-1] & sclk_s[SYNC_N];
  wire cs_l  = ~cs_s[SYNC_N-1];
  wire din_b = din_s[SYNC_N-1];

  wire [7:0]    csum     = res_q[23:16] + res_q[15:8] + res_q[7:0] + CSUM_KEY;
  wire [NB-1:0] word     = {res_q, csum};
  wire [PW-1:0] last     = csum_en ? LAST_C : LAST_D;
  wire [7:0]    cmd_full = {cmd_q, din_b};
  wire cmd_done = fall && cs_l && !frame_q && cbit_q == 3'd7;
  wire hit      = cmd_done && cmd_full == RD_OPC;
  wire in_win   = cnt_q != '0;
  wire start    = hit && !in_win;
  wire end_bnd  = rise && frame_q && pend_q && started_q && ptr_q == '0;
  wire load     = pend_q && !frame_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q   <= '0;
      stage_q <= '0;
      pend_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      if (conv_done) begin
        cnt_q   <= CW'(UPD_CYC);
        stage_q <= conv_data;
      end else if (in_win) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (conv_done)                 pend_q <= 1'b0;
      else if (cnt_q == CW'(1))      pend_q <= 1'b1;
      else if (load)                 pend_q <= 1'b0;
      if (load) res_q <= stage_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      drdy_q  <= 1'b1;
      first_q <= 1'b0;
    end else begin
      if (conv_done)                                    drdy_q <= 1'b1;
      else if (load)                                    drdy_q <= 1'b0;
      else if (fall && frame_q && first_q && !pulse_mode) drdy_q <= 1'b1;
      if (start)                 first_q <= 1'b1;
      else if (fall && frame_q)  first_q <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frame_q   <= 1'b0;
      ptr_q     <= '0;
      started_q <= 1'b0;
      dout_q    <= 1'b0;
    end else begin
      if (!cs_l)        frame_q <= 1'b0;
      else if (start)   frame_q <= 1'b1;
      else if (end_bnd) frame_q <= 1'b0;
      if (start) begin
        ptr_q     <= '0;
        started_q <= 1'b0;
      end else if (frame_q && cs_l && rise && !end_bnd) begin
        ptr_q     <= (ptr_q == last) ? '0 : ptr_q + 1'b1;
        started_q <= 1'b1;
      end
      if (!frame_q || !cs_l) dout_q <= 1'b0;
      else if (rise)         dout_q <= end_bnd ? 1'b0 : word[TOP - ptr_q];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_q  <= '0;
      cbit_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (!cs_l || frame_q) begin
        cbit_q <= '0;
      end else if (fall) begin
        cmd_q  <= cmd_full[6:0];
        cbit_q <= cbit_q + 1'b1;
      end
      err_q <= hit && in_win;
    end

  assign dout     = dout_q;
  assign dout_en  = cs_l;
  assign drdy_n   = drdy_q;
  assign drdy_bit = drdy_q;
  assign rd_err   = err_q;

  a_r8_err_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !frame_q);
  a_r11_res_stable_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_q && $past(frame_q)) |-> $stable(res_q));
  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!frame_q) |-> !dout_q);
  a_r7_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && !drdy_q && !conv_done) |=> !drdy_q);
  a_r5_fall_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_q) |-> $past(pend_q));
  a_r9_cs_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_l |=> !frame_q);
endmodule

// File: tb/adc_rdport_tb_top.sv
`timescale 1ns/1ps
module adc_rdport_tb_top;
  localparam int H = 8;
  logic clk = 0, rst_n = 0, conv_done = 0, csum_en = 0, pulse_mode = 0;
  logic sclk = 0, cs_n = 1, din = 0;
  logic [23:0] conv_data = '0;
  logic dout, dout_en, drdy_n, drdy_bit, rd_err;
  int n_chk = 0, n_bad = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_rdport dut_i (.clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .csum_en(csum_en), .pulse_mode(pulse_mode), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .dout_en(dout_en), .drdy_n(drdy_n), .drdy_bit(drdy_bit), .rd_err(rd_err));

  always @(negedge clk) if (rd_err) n_err++;

  localparam logic [25:0] VEC [4] = '{
    {1'b0, 1'b0, 24'hA5C3_0F},
    {1'b0, 1'b1, 24'h123456},
    {1'b1, 1'b1, 24'hFFFFFF},
    {1'b1, 1'b0, 24'h800001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic o);
    din = b; sclk = 1;
    repeat (H) @(negedge clk);
    o = dout; sclk = 0;
    repeat (H) @(negedge clk);
  endtask

  task automatic send_op(input logic [7:0] op);
    logic o;
    for (int i = 7; i >= 0; i--) begin
      sbit(op[i], o);
      chk("R10 dout low during opcode", o, 0);
    end
  endtask

  task automatic strobe(input logic [23:0] d);
    conv_data = d; conv_done = 1;
    @(negedge clk); conv_done = 0;
  endtask

  task automatic cs_cycle();
    cs_n = 1; repeat (6) @(negedge clk);
    cs_n = 0; repeat (6) @(negedge clk);
  endtask

  task automatic read_frame(input logic [23:0] d, input logic c, input logic p);
    logic [31:0] w;
    logic o;
    int nb;
    w = {d, d[23:16] + d[15:8] + d[7:0] + 8'h9B};
    nb = c ? 32 : 24;
    for (int i = 0; i < nb; i++) begin
      sbit(0, o);
      chk(i < 24 ? "R2 data bit" : "R3 checksum bit", o, w[31-i]);
      if (i == 0) chk(p ? "R7 drdy held in pulse" : "R6 drdy cleared in gate", drdy_n, !p);
    end
    for (int i = 0; i < 8; i++) begin
      sbit(0, o);
      chk("R4 repeat from top", o, d[23-i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic o;
    repeat (5) @(negedge clk);
    chk("R9 reset dout_en", dout_en, 0);
    chk("R5 reset drdy_n", drdy_n, 1);
    chk("R8 reset rd_err", rd_err, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < 4; v++) begin
      pulse_mode = VEC[v][25]; csum_en = VEC[v][24];
      cs_n = 1; repeat (4) @(negedge clk);
      strobe(VEC[v][23:0]);
      repeat (10) @(negedge clk);
      chk("R5 drdy high within window", drdy_n, 1);
      repeat (20) @(negedge clk);
      chk("R5 drdy low after window", drdy_n, 0);
      chk("R12 status mirrors", drdy_bit, drdy_n);
      cs_n = 0; repeat (6) @(negedge clk);
      chk("R10 idle driven", dout_en, 1);
      send_op(8'h12);
      chk("R6 drdy low before data", drdy_n, 0);
      read_frame(VEC[v][23:0], VEC[v][24], VEC[v][25]);
      chk("R12 status mirrors after read", drdy_bit, drdy_n);
      cs_n = 1; repeat (6) @(negedge clk);
      chk("R9 dout_en off with cs high", dout_en, 0);
    end

    pulse_mode = 0; csum_en = 0;
    strobe(24'h3C3C3C); repeat (30) @(negedge clk);
    cs_n = 0; repeat (6) @(negedge clk);
    send_op(8'h13);
    for (int i = 0; i < 8; i++) begin
      sbit(0, o);
      chk("R1 wrong opcode ignored", o, 0);
    end
    chk("R1 drdy untouched by wrong opcode", drdy_n, 0);

    cs_cycle();
    for (int i = 7; i >= 1; i--) sbit(RD_BIT(i), o);
    strobe(24'h5A5A5A);
    sbit(0, o);
    repeat (2) @(negedge clk);
    chk("R8 rd_err counted", n_err, 1);
    for (int i = 0; i < 8; i++) begin
      sbit(0, o);
      chk("R8 no frame after refusal", o, 0);
    end
    repeat (30) @(negedge clk);
    cs_cycle();
    for (int i = 7; i >= 1; i--) sbit(RD_BIT(i), o);
    strobe(24'h0F0F0F);
    repeat (30) @(negedge clk);
    sbit(0, o);
    chk("R8 accepted after window", n_err, 1);
    for (int i = 0; i < 24; i++) begin
      sbit(0, o);
      chk("R2 late accept data", o, 24'h0F0F0F >> (23 - i) & 1);
    end

    cs_cycle();
    send_op(8'h12);
    for (int i = 0; i < 5; i++) begin
      sbit(0, o);
      chk("R11 old data before strobe", o, 24'h0F0F0F >> (23 - i) & 1);
    end
    strobe(24'hC0FFEE);
    repeat (30) @(negedge clk);
    chk("R11 load deferred", drdy_n, 1);
    for (int i = 5; i < 24; i++) begin
      sbit(0, o);
      chk("R11 old data after strobe", o, 24'h0F0F0F >> (23 - i) & 1);
    end
    sbit(0, o);
    chk("R11 frame ends at boundary", o, 0);
    chk("R11 load at boundary", drdy_n, 0);
    cs_cycle();
    send_op(8'h12);
    for (int i = 0; i < 24; i++) begin
      sbit(0, o);
      chk("R11 new data", o, 24'hC0FFEE >> (23 - i) & 1);
    end
    cs_n = 1; repeat (6) @(negedge clk);
    chk("R9 released", dout_en, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic RD_BIT(input int i);
    logic [7:0] op = 8'h12;
    return op[i];
  endfunction
endmodule